// File: doc/BRIEF.md
# Latched Nonvolatile Array Program/Erase Controller

This block is a memory-mapped controller for an on-chip nonvolatile byte array, with the array cells modelled as registers. A CPU-side bus reads and writes it one byte per cycle. A control register switches the array between two uses. In normal mode it serves plain reads. In latched mode a bus write to an array location does not reach the cells: it stores the target offset and data in holding latches.

Setting the arm bit starts a timed high-voltage phase of `PUMP_CYCLES` clocks. At its end the latched operation is applied to the cells. The operation can be a program, which only clears bits, or an erase of a byte, a 16-byte row or the whole array. Clearing the arm bit before the timer expires cancels the operation.

A protect register guards four equal quarters of the array and a configuration byte. Software can change it only in a short window after reset. The upper nibble of the configuration byte places the array on a 4 KB boundary of the 16-bit address map. A changed configuration value takes effect only at the next reset.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the protect register reads 0x1F and `busy` is 0.
- R2: With the latch bit clear, an array read returns the stored byte, and a bus write to an array location leaves that byte unchanged.
- R3: Control bit 1 is the latch bit. While it is set, array reads return 0xFF, `busy` is 1, and a write to an array location or to the configuration byte is captured (offset and data) for the next operation.
- R4: Control bit 0 is the arm bit. It becomes 1 only from a control write that has bits 1 and 0 both set while the latch bit is already 1. Any other write leaves the arm bit at 0.
- R5: The operation is applied exactly `PUMP_CYCLES` clock edges after the arming edge. The arm bit reads 1 until then and 0 from that point on.
- R6: A program operation stores the old byte ANDed with the latched data, so it can only clear bits.
- R7: Mode bits are bit 2 erase, bit 3 row and bit 4 byte. erase=0 means program. erase=1 with byte=1 erases the latched byte. erase=1, byte=0, row=1 erases the aligned 16-byte row that holds the latched offset. erase=1, byte=0, row=0 is a bulk erase. Erased bytes read 0xFF.
- R8: A bulk erase sets every unprotected array byte to 0xFF and leaves the configuration byte unchanged.
- R9: The protect register holds region bits 3..0 and a configuration bit 4, and resets to all ones. Writes change it only during the first `PROT_WINDOW` clock edges after reset; later writes are ignored.
- R10: Protect bit k guards array offsets k*ARRAY_BYTES/4 up to (k+1)*ARRAY_BYTES/4-1. Program and erase leave a guarded byte unchanged.
- R11: While protect bit 4 is set, program and erase of the configuration byte leave it unchanged.
- R12: A read of the configuration address returns the stored value at once. The array base (configuration bits 7..4 as address bits 15..12) and the `cfg_live` output change only when reset is applied. A read that hits neither the array nor a register returns 0x00.
- R13: A control write with bit 0 clear while an operation runs cancels it, and the cells are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the configuration value is applied while it is low |
| bus_addr | input | 16 | Bus byte address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Bus write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr`, same cycle |
| busy | output | 1 | Latched mode active; array not readable |
| cfg_live | output | 8 | Configuration value in effect since the last reset |

## Verification
A register write takes effect at the edge where the strobe is high and can be read back in the following cycle. Reads are combinational, so the bench drives on the falling edge and samples 1 ns later. A program or erase changes the cells at the edge `PUMP_CYCLES` after the arming edge. The bench reads the arm bit one cycle before and one cycle after that edge, and the table waits `PUMP_CYCLES`+2 cycles before it reads a result. A new configuration base is checked only after a second reset pulse, with the clock running.

// File: rtl/nvm_pe_pkg.sv
package nvm_pe_pkg;

   localparam int NUM_REGIONS  = 4;
   localparam int BUS_AW       = 16;
   localparam int PAGE_BITS    = 12;

   // control register bit positions
   localparam int CB_ARM   = 0;
   localparam int CB_LATCH = 1;
   localparam int CB_ERASE = 2;
   localparam int CB_ROW   = 3;
   localparam int CB_BYTE  = 4;

   localparam int PB_CFG   = NUM_REGIONS;

   typedef enum logic [1:0] {
      OP_PROGRAM    = 2'd0,
      OP_BYTE_ERASE = 2'd1,
      OP_ROW_ERASE  = 2'd2,
      OP_BULK_ERASE = 2'd3
   } nvm_op_e;

   typedef struct packed {
      logic byte_m;
      logic row_m;
      logic erase_m;
   } nvm_mode_t;

   function automatic nvm_op_e mode_to_op(input nvm_mode_t m);
      if (!m.erase_m)    return OP_PROGRAM;
      else if (m.byte_m) return OP_BYTE_ERASE;
      else if (m.row_m)  return OP_ROW_ERASE;
      else               return OP_BULK_ERASE;
   endfunction

endpackage

// File: rtl/nvm_pe_pump_timer.sv
module nvm_pe_pump_timer #(
   parameter int PUMP_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   output logic running,
   output logic done
);
   localparam int CW = $clog2(PUMP_CYCLES + 1);

   logic [CW-1:0] cnt_q;
   logic          run_q;

   initial begin
      assert (PUMP_CYCLES >= 2) else $error("PUMP_CYCLES must be at least 2");
   end

   assign running = run_q;
   assign done    = run_q && (cnt_q == CW'(1)) && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         cnt_q <= CW'(PUMP_CYCLES);
      end else if (abort) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (run_q) begin
         if (cnt_q == CW'(1)) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end
endmodule

// File: rtl/nvm_pe_protect.sv
module nvm_pe_protect
   import nvm_pe_pkg::*;
#(
   parameter int PROT_WINDOW = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [NUM_REGIONS:0]   wdata,
   output logic [NUM_REGIONS:0]   prot,
   output logic                   win_open
);
   localparam int WW = $clog2(PROT_WINDOW + 1);

   logic [WW-1:0] age_q;

   initial begin
      assert (PROT_WINDOW >= 1) else $error("PROT_WINDOW must be positive");
   end

   assign win_open = (age_q < WW'(PROT_WINDOW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q <= '0;
         prot  <= '1;
      end else begin
         if (win_open) age_q <= age_q + WW'(1);
         if (wr && win_open) prot <= wdata;
      end
   end
endmodule

// File: rtl/nvm_pe_ctrl_regs.sv
module nvm_pe_ctrl_regs
   import nvm_pe_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_wr,
   input  logic [4:0]    ctrl_wdata,
   input  logic          cap_wr,
   input  logic [AW-1:0] cap_off,
   input  logic [7:0]    cap_data,
   input  logic          cap_cfg,
   input  logic          running,
   output logic          start,
   output logic          abort,
   output logic          latch,
   output nvm_mode_t     mode,
   output logic [AW-1:0] lat_off,
   output logic [7:0]    lat_data,
   output logic          lat_cfg
);
   assign start = ctrl_wr && !running && latch &&
                  ctrl_wdata[CB_ARM] && ctrl_wdata[CB_LATCH];
   assign abort = ctrl_wr && running && !ctrl_wdata[CB_ARM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch    <= 1'b0;
         mode     <= '0;
         lat_off  <= '0;
         lat_data <= 8'hFF;
         lat_cfg  <= 1'b0;
      end else begin
         if (ctrl_wr && !running) begin
            latch        <= ctrl_wdata[CB_LATCH];
            mode.erase_m <= ctrl_wdata[CB_ERASE];
            mode.row_m   <= ctrl_wdata[CB_ROW];
            mode.byte_m  <= ctrl_wdata[CB_BYTE];
         end
         if (cap_wr) begin
            lat_off  <= cap_off;
            lat_data <= cap_data;
            lat_cfg  <= cap_cfg;
         end
      end
   end
endmodule

// File: rtl/nvm_pe_cells.sv
module nvm_pe_cells
   import nvm_pe_pkg::*;
#(
   parameter int         ARRAY_BYTES = 256,
   parameter int         ROW_BYTES   = 16,
   parameter logic [7:0] CFG_INIT    = 8'h10,
   localparam int        AW          = $clog2(ARRAY_BYTES)
) (
   input  logic                 clk,
   input  logic                 commit,
   input  nvm_op_e              op,
   input  logic [AW-1:0]        lat_off,
   input  logic [7:0]           lat_data,
   input  logic                 lat_cfg,
   input  logic [NUM_REGIONS:0] prot,
   input  logic [AW-1:0]        rd_off,
   output logic [7:0]           rd_data,
   output logic [7:0]           cfg_val
);
   localparam int RW        = $clog2(ROW_BYTES);
   localparam int REG_BYTES = ARRAY_BYTES / NUM_REGIONS;

   initial begin
      assert (ROW_BYTES >= 2 && (1 << RW) == ROW_BYTES)
         else $error("ROW_BYTES must be a power of two");
      assert (REG_BYTES % ROW_BYTES == 0)
         else $error("a region must hold whole rows");
   end

   logic [7:0] cell_mem [ARRAY_BYTES];

   for (genvar g = 0; g < ARRAY_BYTES; g++) begin : g_cell
      localparam int REGI = g / REG_BYTES;
      localparam int ROWI = g / ROW_BYTES;

      logic [7:0] cell_q = 8'hFF;   // shipped erased
      logic       hit_byte, hit_row;

      assign hit_byte = (lat_off == AW'(g)) && !lat_cfg;
      assign hit_row  = (lat_off[AW-1:RW] == (AW-RW)'(ROWI)) && !lat_cfg;

      always_ff @(posedge clk) begin
         if (commit && !prot[REGI]) begin
            case (op)
               OP_PROGRAM:    if (hit_byte) cell_q <= cell_q & lat_data;
               OP_BYTE_ERASE: if (hit_byte) cell_q <= 8'hFF;
               OP_ROW_ERASE:  if (hit_row)  cell_q <= 8'hFF;
               default:                     cell_q <= 8'hFF;
            endcase
         end
      end

      assign cell_mem[g] = cell_q;
   end

   logic [7:0] cfg_q = CFG_INIT;

   always_ff @(posedge clk) begin
      if (commit && lat_cfg && !prot[PB_CFG] && op != OP_BULK_ERASE) begin
         if (op == OP_PROGRAM) cfg_q <= cfg_q & lat_data;
         else                  cfg_q <= 8'hFF;
      end
   end

   assign cfg_val = cfg_q;
   assign rd_data = cell_mem[rd_off];
endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
   import nvm_pe_pkg::*;
#(
   parameter int          ARRAY_BYTES = 256,
   parameter int          ROW_BYTES   = 16,
   parameter int          PUMP_CYCLES = 500000,
   parameter int          PROT_WINDOW = 64,
   parameter logic [15:0] CTRL_ADDR   = 16'h0030,
   parameter logic [15:0] PROT_ADDR   = 16'h0031,
   parameter logic [15:0] CFG_ADDR    = 16'h0032,
   parameter logic [7:0]  CFG_INIT    = 8'h10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] bus_addr,
   input  logic [7:0]  bus_wdata,
   input  logic        bus_we,
   output logic [7:0]  bus_rdata,
   output logic        busy,
   output logic [7:0]  cfg_live
);
   localparam int AW = $clog2(ARRAY_BYTES);

   initial begin
      assert (ARRAY_BYTES >= 2*NUM_REGIONS && ARRAY_BYTES <= (1 << (PAGE_BITS-1)))
         else $error("ARRAY_BYTES out of range");
      assert ((1 << AW) == ARRAY_BYTES) else $error("ARRAY_BYTES must be a power of two");
   end

   logic                 ctrl_hit, prot_hit, cfg_hit, reg_hit, arr_hit;
   logic                 ctrl_wr, prot_wr, cap_wr;
   logic                 start, abort, running, pump_done, latch, lat_cfg, win_open;
   nvm_mode_t            mode;
   nvm_op_e              op;
   logic [AW-1:0]        lat_off;
   logic [7:0]           lat_data, arr_rd, cfg_val;
   logic [NUM_REGIONS:0] prot;
   logic [7:0]           cfg_live_q;

   // ---------------- address decode ----------------
   assign ctrl_hit = (bus_addr == CTRL_ADDR);
   assign prot_hit = (bus_addr == PROT_ADDR);
   assign cfg_hit  = (bus_addr == CFG_ADDR);
   assign reg_hit  = ctrl_hit || prot_hit || cfg_hit;
   assign arr_hit  = !reg_hit &&
                     (bus_addr[BUS_AW-1:PAGE_BITS] == cfg_live_q[7:4]) &&
                     (bus_addr[PAGE_BITS-1:AW] == '0);

   assign ctrl_wr = bus_we && ctrl_hit;
   assign prot_wr = bus_we && prot_hit;
   assign cap_wr  = bus_we && latch && !running && (arr_hit || cfg_hit);

   // ---------------- configuration applied at reset ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) cfg_live_q <= cfg_val;
   end
   assign cfg_live = cfg_live_q;

   // ---------------- sub-blocks ----------------
   nvm_pe_ctrl_regs #(.AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(bus_wdata[4:0]),
      .cap_wr(cap_wr), .cap_off(bus_addr[AW-1:0]), .cap_data(bus_wdata),
      .cap_cfg(cfg_hit), .running(running),
      .start(start), .abort(abort), .latch(latch), .mode(mode),
      .lat_off(lat_off), .lat_data(lat_data), .lat_cfg(lat_cfg)
   );

   nvm_pe_pump_timer #(.PUMP_CYCLES(PUMP_CYCLES)) u_pump (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .running(running), .done(pump_done)
   );

   nvm_pe_protect #(.PROT_WINDOW(PROT_WINDOW)) u_prot (
      .clk(clk), .rst_n(rst_n), .wr(prot_wr),
      .wdata(bus_wdata[NUM_REGIONS:0]), .prot(prot), .win_open(win_open)
   );

   assign op = mode_to_op(mode);

   nvm_pe_cells #(
      .ARRAY_BYTES(ARRAY_BYTES), .ROW_BYTES(ROW_BYTES), .CFG_INIT(CFG_INIT)
   ) u_cells (
      .clk(clk), .commit(pump_done), .op(op),
      .lat_off(lat_off), .lat_data(lat_data), .lat_cfg(lat_cfg),
      .prot(prot), .rd_off(bus_addr[AW-1:0]), .rd_data(arr_rd), .cfg_val(cfg_val)
   );

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = 8'h00;
      if (ctrl_hit)
         bus_rdata = {3'b000, mode.byte_m, mode.row_m, mode.erase_m, latch, running};
      else if (prot_hit)
         bus_rdata = 8'(prot);
      else if (cfg_hit)
         bus_rdata = cfg_val;
      else if (arr_hit)
         bus_rdata = latch ? 8'hFF : arr_rd;
   end

   assign busy = latch;
endmodule

// File: rtl/nvm_pe_chk.sv
module nvm_pe_chk #(
   parameter int PUMP_CYCLES = 500000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       latch,
   input logic       running,
   input logic       pump_done,
   input logic       arr_hit,
   input logic [7:0] bus_rdata,
   input logic [7:0] cfg_live,
   input logic [4:0] prot,
   input logic       win_open,
   input logic       ctrl_wr,
   input logic       wbit0
);
   logic [31:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_cnt <= '0;
      else if (!running) run_cnt <= '0;
      else               run_cnt <= run_cnt + 32'd1;
   end

   assert_busy_reads_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && arr_hit) |-> (bus_rdata == 8'hFF));

   assert_arm_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(latch));

   assert_pump_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pump_done |-> (run_cnt == 32'(PUMP_CYCLES - 1)));

   assert_prot_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(win_open)) |-> $stable(prot));

   assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(cfg_live));

   assert_abort_stops_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && running && !wbit0) |=> !running);
endmodule

bind nvm_pe_ctrl nvm_pe_chk #(.PUMP_CYCLES(PUMP_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .latch(latch), .running(running),
   .pump_done(pump_done), .arr_hit(arr_hit), .bus_rdata(bus_rdata),
   .cfg_live(cfg_live), .prot(prot), .win_open(win_open),
   .ctrl_wr(ctrl_wr), .wbit0(bus_wdata[0])
);

// File: tb/sim_nvm_pe_ctrl.sv
module sim_nvm_pe_ctrl;
   localparam int P = 40;
   localparam logic [15:0] CT = 16'h0030;
   localparam logic [15:0] PR = 16'h0031;
   localparam logic [15:0] CF = 16'h0032;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_rdata;
   logic        busy;
   logic [7:0]  cfg_live;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #10 clk = ~clk;   // 50 MHz

   nvm_pe_ctrl #(.PUMP_CYCLES(P)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .busy(busy), .cfg_live(cfg_live)
   );

   // {kind(2): 0 write / 1 read / 2 wait, req(4), addr(16), data(8), expected(8)}
   localparam int NT = 56;
   localparam logic [37:0] TBL [NT] = '{
      {2'd0, 4'd9,  PR,       8'h08, 8'h00},  // R9 clear protection inside window
      {2'd1, 4'd9,  PR,       8'h00, 8'h08},  // R9
      {2'd1, 4'd2,  16'h1005, 8'h00, 8'hFF},  // R2 erased cell
      {2'd0, 4'd3,  CT,       8'h02, 8'h00},  // R3 latch on
      {2'd0, 4'd3,  16'h1005, 8'hA5, 8'h00},
      {2'd1, 4'd3,  16'h1005, 8'h00, 8'hFF},  // R3 reads FF while latched
      {2'd1, 4'd3,  CT,       8'h00, 8'h02},
      {2'd0, 4'd6,  CT,       8'h03, 8'h00},
      {2'd2, 4'd6,  16'h0000, 8'h00, 8'h00},
      {2'd0, 4'd6,  CT,       8'h00, 8'h00},
      {2'd1, 4'd6,  16'h1005, 8'h00, 8'hA5},  // R6
      {2'd0, 4'd6,  CT,       8'h02, 8'h00},
      {2'd0, 4'd6,  16'h1005, 8'h0F, 8'h00},
      {2'd0, 4'd6,  CT,       8'h03, 8'h00},
      {2'd2, 4'd6,  16'h0000, 8'h00, 8'h00},
      {2'd0, 4'd6,  CT,       8'h00, 8'h00},
      {2'd1, 4'd6,  16'h1005, 8'h00, 8'h05},  // R6 A5 & 0F
      {2'd0, 4'd7,  CT,       8'h02, 8'h00},
      {2'd0, 4'd7,  16'h1015, 8'h33, 8'h00},
      {2'd0, 4'd7,  CT,       8'h03, 8'h00},
      {2'd2, 4'd7,  16'h0000, 8'h00, 8'h00},
      {2'd0, 4'd7,  16'h1016, 8'h66, 8'h00},
      {2'd0, 4'd7,  CT,       8'h03, 8'h00},
      {2'd2, 4'd7,  16'h0000, 8'h00, 8'h00},
      {2'd0, 4'd7,  CT,       8'h0E, 8'h00},  // R7 row erase mode
      {2'd0, 4'd7,  16'h1007, 8'h00, 8'h00},
      {2'd0, 4'd7,  CT,       8'h0F, 8'h00},
      {2'd2, 4'd7,  16'h0000, 8'h00, 8'h00},
      {2'd0, 4'd7,  CT,       8'h00, 8'h00},
      {2'd1, 4'd7,  16'h1005, 8'h00, 8'hFF},  // R7 row 0 erased
      {2'd1, 4'd7,  16'h1015, 8'h00, 8'h33},  // R7 row 1 kept
      {2'd0, 4'd7,  CT,       8'h16, 8'h00},  // R7 byte erase mode
      {2'd0, 4'd7,  16'h1015, 8'h00, 8'h00},
      {2'd0, 4'd7,  CT,       8'h17, 8'h00},
      {2'd2, 4'd7,  16'h0000, 8'h00, 8'h00},
      {2'd0, 4'd7,  CT,       8'h00, 8'h00},
      {2'd1, 4'd7,  16'h1015, 8'h00, 8'hFF},  // R7
      {2'd1, 4'd7,  16'h1016, 8'h00, 8'h66},  // R7 neighbour kept
      {2'd0, 4'd10, CT,       8'h02, 8'h00},
      {2'd0, 4'd10, 16'h10C0, 8'h00, 8'h00},
      {2'd0, 4'd10, CT,       8'h03, 8'h00},
      {2'd2, 4'd10, 16'h0000, 8'h00, 8'h00},
      {2'd0, 4'd10, CT,       8'h00, 8'h00},
      {2'd1, 4'd10, 16'h10C0, 8'h00, 8'hFF},  // R10 quarter 3 guarded
      {2'd0, 4'd11, CT,       8'h16, 8'h00},
      {2'd0, 4'd11, CF,       8'h00, 8'h00},
      {2'd0, 4'd11, CT,       8'h17, 8'h00},
      {2'd2, 4'd11, 16'h0000, 8'h00, 8'h00},
      {2'd1, 4'd11, CF,       8'h00, 8'hFF},  // R11 unguarded config erase
      {2'd0, 4'd12, CT,       8'h02, 8'h00},
      {2'd0, 4'd12, CF,       8'h5F, 8'h00},
      {2'd0, 4'd12, CT,       8'h03, 8'h00},
      {2'd2, 4'd12, 16'h0000, 8'h00, 8'h00},
      {2'd0, 4'd12, CT,       8'h00, 8'h00},
      {2'd1, 4'd12, CF,       8'h00, 8'h5F},  // R12 stored value visible
      {2'd1, 4'd12, 16'h1016, 8'h00, 8'h66}   // R12 base not yet moved
   };

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rchk(input logic [15:0] a, input logic [7:0] e, input string tag);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, e);
   endtask

   task automatic pwait;
      repeat (P + 2) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rchk(CT, 8'h00, "R1 ctrl");
      rchk(PR, 8'h1F, "R1 prot");
      chk("R1 busy", {7'd0, busy}, 8'h00);
      rchk(CF, 8'h10, "R12 cfg init");
      chk("R12 cfg_live", cfg_live, 8'h10);

      for (int i = 0; i < NT; i++) begin
         logic [1:0]  k;
         logic [3:0]  rq;
         logic [15:0] a;
         logic [7:0]  d, e;
         {k, rq, a, d, e} = TBL[i];
         case (k)
            2'd0: wr(a, d);
            2'd1: rchk(a, e, $sformatf("R%0d table entry %0d", rq, i));
            default: pwait();
         endcase
      end

      // R8 bulk erase
      wr(CT, 8'h02); wr(16'h1050, 8'h12); wr(CT, 8'h03); pwait();
      wr(CT, 8'h00);
      rchk(16'h1050, 8'h12, "R6 quarter 1");
      wr(CT, 8'h06); wr(16'h1000, 8'h00); wr(CT, 8'h07); pwait(); wr(CT, 8'h00);
      rchk(16'h1050, 8'hFF, "R8 bulk");
      rchk(16'h1016, 8'hFF, "R8 bulk");
      rchk(CF, 8'h5F, "R8 config kept");

      // R13 abort
      wr(CT, 8'h02); wr(16'h1020, 8'h00); wr(CT, 8'h03);
      rchk(CT, 8'h03, "R13 armed");
      wr(CT, 8'h02);
      rchk(CT, 8'h02, "R13 aborted");
      pwait(); wr(CT, 8'h00);
      rchk(16'h1020, 8'hFF, "R13 cell kept");

      // R4 arming rules
      wr(CT, 8'h01);
      rchk(CT, 8'h00, "R4 arm without latch");
      wr(CT, 8'h03);
      rchk(CT, 8'h02, "R4 latch not yet set");
      chk("R3 busy", {7'd0, busy}, 8'h01);
      rchk(16'h1030, 8'hFF, "R3 latched read");
      pwait();
      rchk(CT, 8'h02, "R4 no operation");
      wr(CT, 8'h00);

      // R2 direct write ignored
      wr(16'h1030, 8'h00);
      rchk(16'h1030, 8'hFF, "R2 direct write");

      // R9 window closed
      wr(PR, 8'h00);
      rchk(PR, 8'h08, "R9 locked");
      chk("R12 cfg_live held", cfg_live, 8'h10);

      // R5 timing of the pump phase
      wr(CT, 8'h02); wr(16'h1017, 8'h3C); wr(CT, 8'h03);
      rchk(CT, 8'h03, "R5 start");
      repeat (P - 1) @(negedge clk);
      rchk(CT, 8'h03, "R5 last busy cycle");
      @(negedge clk);
      rchk(CT, 8'h02, "R5 done");
      wr(CT, 8'h00);
      rchk(16'h1017, 8'h3C, "R5 result");

      // second reset applies the new base
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R12 cfg_live new", cfg_live, 8'h5F);
      rchk(16'h5017, 8'h3C, "R12 new base");
      rchk(16'h1017, 8'h00, "R12 old base unmapped");
      rchk(PR, 8'h1F, "R1 prot after reset");
      rchk(CT, 8'h00, "R1 ctrl after reset");

      // R11 config guarded
      wr(CT, 8'h16); wr(CF, 8'h00); wr(CT, 8'h17); pwait(); wr(CT, 8'h00);
      rchk(CF, 8'h5F, "R11 config guarded");

      // R10 all quarters guarded
      wr(CT, 8'h16); wr(16'h5017, 8'h00); wr(CT, 8'h17); pwait(); wr(CT, 8'h00);
      rchk(16'h5017, 8'h3C, "R10 quarter 0 guarded");

      finish_run();
   end
endmodule